// File: doc/BRIEF.md
# Serial EEPROM Configuration-Word Loader

At power-up, a serial EEPROM reader delivers 16-bit words to this block over a valid/ready stream. The block turns those words into updates of a small shadow copy of PCI configuration-space bytes. The stream is a zone of function headers. Each header is followed by a run of configuration words. A configuration word carries a 7-bit byte offset and an 8-bit value.

Only fifteen byte offsets can be written. The flag byte at offset 0x06 keeps just one programmable bit. Words aimed at any other offset pass through with no effect. Words that follow a header naming a reserved function are also discarded. When a header with its top bit clear arrives, loading ends: the block raises a done flag and stops accepting words. The shadow bytes are outputs that the configuration-space logic reads.

Top module: `cfgWordLoader`

## Requirements
- R1: During reset, and after it until a write lands, each shadow byte holds its default `(offset ^ 0x5A) & mask`, where mask is 0x10 for offset 0x06 and 0xFF for all others. After reset `loadDone` is 0 and `wordReady` is 1.
- R2: `shadowBytes[8k+7:8k]` is slot k. Slots 0..14 map to offsets 0x00, 0x01, 0x02, 0x03, 0x06, 0x09, 0x0A, 0x0B, 0x2C, 0x2D, 0x2E, 0x2F, 0x3D, 0x42, 0x43, in that order.
- R3: A header word with bit 15 = 1 and bits 2:0 = 000 enables the configuration words that follow it. Bits 14:3 of a header are ignored. Each such configuration word writes bits 7:0 into the slot whose offset equals bits 14:8, and the new value is visible on the clock edge that accepts the word.
- R4: In a configuration word, bit 15 = 1 means another configuration word follows. Bit 15 = 0 marks the last one; that word is still applied, and the next word is parsed as a header.
- R5: A write to offset 0x06 keeps only bit 4 of the value. Bits 7:5 and 3:0 of that slot always read 0.
- R6: A configuration word whose offset is not among the fifteen slots is consumed and changes no shadow byte.
- R7: After a header whose bits 2:0 are not 000, the configuration words are consumed without writing anything, up to and including the one with bit 15 = 0.
- R8: A header word with bit 15 = 0 sets `loadDone` from the next edge on and drops `wordReady`. Both stay that way until reset, and no later word changes a shadow byte.
- R9: A cycle with `wordValid` low changes neither the shadow bytes nor the parse position, whatever is on `wordData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | A word is offered on wordData |
| wordData | input | 16 | EEPROM word (header or configuration word) |
| wordReady | output | 1 | Block accepts a word this cycle |
| loadDone | output | 1 | End-of-zone header seen |
| shadowBytes | output | 120 | Fifteen shadow bytes, slot k at bits 8k+7:8k |

## Verification
The last configuration word of a function does two things in the same cycle: it writes its byte, and it hands the next word back to header parsing. The bench provokes this by holding `wordValid` high through that word and the header that follows it, so nothing separates them. It then judges both effects: the byte written by the closing word must show up, and the following word must behave as a header (select a function, or end the zone), not as data. A cycle-by-cycle reference model flags any slip, whether the write is dropped or the parse position is one word off.

// File: rtl/cfgLoadPkg.sv
package cfgLoadPkg;
  localparam int WORD_W    = 16;
  localparam int OFF_W     = 7;
  localparam int BYTE_W    = 8;
  localparam int FUNC_W    = 3;
  localparam int NUM_SLOTS = 15;
  localparam int MORE_BIT  = WORD_W - 1;

  typedef struct packed {
    logic              wrEn;
    logic [OFF_W-1:0]  wrOff;
    logic [BYTE_W-1:0] wrVal;
  } wrStrobe_t;

  typedef enum logic [1:0] {ST_HDR, ST_CFG, ST_SKIP, ST_DONE} loadState_t;

  // slot order is part of the output layout
  function automatic logic [OFF_W-1:0] slotOffset(input int slot);
    case (slot)
      0: return 7'h00;  1: return 7'h01;  2: return 7'h02;  3: return 7'h03;
      4: return 7'h06;  5: return 7'h09;  6: return 7'h0A;  7: return 7'h0B;
      8: return 7'h2C;  9: return 7'h2D; 10: return 7'h2E; 11: return 7'h2F;
      12: return 7'h3D; 13: return 7'h42; default: return 7'h43;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] slotMask(input int slot);
    return (slotOffset(slot) == 7'h06) ? 8'h10 : 8'hFF;
  endfunction
endpackage

// File: rtl/cfgLoadCtrl.sv
module cfgLoadCtrl
  import cfgLoadPkg::*;
#(
  parameter logic [FUNC_W-1:0] LIVE_FUNC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              wordReady,
  output logic              loadDone,
  output wrStrobe_t         strobe
);
  loadState_t state, stateNext;
  logic       accept;
  logic       moreFlag;

  assign wordReady = (state != ST_DONE);
  assign loadDone  = (state == ST_DONE);
  assign accept    = wordValid && wordReady;
  assign moreFlag  = wordData[MORE_BIT];

  always_comb begin
    stateNext    = state;
    strobe.wrEn  = 1'b0;
    strobe.wrOff = wordData[MORE_BIT-1 -: OFF_W];
    strobe.wrVal = wordData[BYTE_W-1:0];
    if (accept) begin
      case (state)
        ST_HDR: begin
          if (!moreFlag)                                stateNext = ST_DONE;
          else if (wordData[FUNC_W-1:0] == LIVE_FUNC)   stateNext = ST_CFG;
          else                                          stateNext = ST_SKIP;
        end
        ST_CFG: begin
          strobe.wrEn = 1'b1;
          if (!moreFlag) stateNext = ST_HDR;
        end
        ST_SKIP: begin
          if (!moreFlag) stateNext = ST_HDR;
        end
        default: stateNext = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HDR;
    else       state <= stateNext;
  end
endmodule

// File: rtl/cfgShadowRegs.sv
module cfgShadowRegs
  import cfgLoadPkg::*;
#(
  parameter logic [BYTE_W-1:0] DEF_SEED = 8'h5A
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  wrStrobe_t                   strobe,
  output logic [NUM_SLOTS*BYTE_W-1:0] shadowBytes
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    localparam logic [OFF_W-1:0]  SLOT_OFF  = slotOffset(g);
    localparam logic [BYTE_W-1:0] SLOT_MASK = slotMask(g);
    localparam logic [BYTE_W-1:0] SLOT_DEF  =
      ({{(BYTE_W-OFF_W){1'b0}}, SLOT_OFF} ^ DEF_SEED) & SLOT_MASK;
    logic [BYTE_W-1:0] slotReg;

    always_ff @(posedge clk) begin
      if (!rstN)
        slotReg <= SLOT_DEF;
      else if (strobe.wrEn && strobe.wrOff == SLOT_OFF)
        slotReg <= strobe.wrVal & SLOT_MASK;
    end

    assign shadowBytes[g*BYTE_W +: BYTE_W] = slotReg;
  end
endmodule

// File: rtl/cfgWordLoader.sv
module cfgWordLoader
  import cfgLoadPkg::*;
#(
  parameter logic [FUNC_W-1:0] LIVE_FUNC = '0,
  parameter logic [BYTE_W-1:0] DEF_SEED  = 8'h5A
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wordValid,
  input  logic [WORD_W-1:0]           wordData,
  output logic                        wordReady,
  output logic                        loadDone,
  output logic [NUM_SLOTS*BYTE_W-1:0] shadowBytes
);
  wrStrobe_t strobe;

  cfgLoadCtrl #(.LIVE_FUNC(LIVE_FUNC)) uCtrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .wordReady(wordReady), .loadDone(loadDone), .strobe(strobe)
  );

  cfgShadowRegs #(.DEF_SEED(DEF_SEED)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shadowBytes(shadowBytes)
  );
endmodule

// File: rtl/cfgWordLoaderChk.sv
module cfgWordLoaderChk
  import cfgLoadPkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        wordValid,
  input logic [WORD_W-1:0]           wordData,
  input logic                        wordReady,
  input logic                        loadDone,
  input logic [NUM_SLOTS*BYTE_W-1:0] shadowBytes
);
  localparam int EXT_SLOT = 4;

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);

  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> $past(wordValid && wordReady && !wordData[MORE_BIT]));

  a_r8_frozen_after_done: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> $stable(shadowBytes));

  a_r9_idle_no_change: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid && wordReady) |=> $stable(shadowBytes));

  a_r5_ext_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (shadowBytes[EXT_SLOT*BYTE_W +: BYTE_W] & 8'hEF) == 8'h00);
endmodule

bind cfgWordLoader cfgWordLoaderChk uChk (
  .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
  .wordReady(wordReady), .loadDone(loadDone), .shadowBytes(shadowBytes)
);

// File: tb/cfgWordLoader_test.sv
module cfgWordLoader_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wordValid = 1'b0;
  logic [15:0]  wordData = 16'h0000;
  logic         wordReady;
  logic         loadDone;
  logic [119:0] shadowBytes;

  cfgWordLoader uut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .wordReady(wordReady), .loadDone(loadDone), .shadowBytes(shadowBytes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nRun = 0;
  int    nFail = 0;
  string curReq = "R1";
  bit    finished = 0;
  int    offs[15] = '{0, 1, 2, 3, 6, 9, 10, 11, 44, 45, 46, 47, 61, 66, 67};

  // behavioural reference: offset-keyed byte store plus parse mode
  int refMem[int];
  int refMode;   // 0 header, 1 apply, 2 discard, 3 finished
  bit refDone;
  int wOff;

  function automatic int maskOf(int off);
    return (off == 6) ? 'h10 : 'hFF;
  endfunction

  function automatic int defOf(int off);
    return (off ^ 'h5A) & maskOf(off);
  endfunction

  function automatic int slotVal(int k);
    return int'(shadowBytes[k*8 +: 8]);
  endfunction

  task automatic modelReset();
    foreach (offs[i]) refMem[offs[i]] = defOf(offs[i]);
    refMode = 0;
    refDone = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else if (wordValid && !refDone) begin
      case (refMode)
        0: if (!wordData[15]) begin refMode = 3; refDone = 1; end
           else refMode = (wordData[2:0] == 3'd0) ? 1 : 2;
        1: begin
          wOff = int'(wordData[14:8]);
          if (refMem.exists(wOff)) refMem[wOff] = int'(wordData[7:0]) & maskOf(wOff);
          if (!wordData[15]) refMode = 0;
        end
        2: if (!wordData[15]) refMode = 0;
        default: ;
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      foreach (offs[i]) chk(curReq, "model slot", slotVal(i), refMem[offs[i]]);
      chk(curReq, "model loadDone", int'(loadDone), int'(refDone));
      chk(curReq, "model wordReady", int'(wordReady), int'(!refDone));
    end
  end

  task automatic sendWord(logic [15:0] w);
    @(negedge clk);
    wordValid = 1'b1;
    wordData  = w;
    @(posedge clk);
  endtask

  task automatic idle(int n, logic [15:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wordValid = 1'b0;
      wordData  = junk;
      @(posedge clk);
    end
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R2: defaults per slot
    foreach (offs[i]) chk("R1", "default slot", slotVal(i), defOf(offs[i]));
    chk("R1", "loadDone after reset", int'(loadDone), 0);
    chk("R1", "wordReady after reset", int'(wordReady), 1);

    // R3: live function, continue flags set
    curReq = "R3";
    sendWord(16'h8000);
    sendWord(16'h8012);              // offset 0x00 <- 0x12
    curReq = "R5";
    sendWord(16'h86FF);              // offset 0x06 <- 0xFF, only bit 4 kept
    idle(1, 16'h0000);
    chk("R3", "slot 0 written", slotVal(0), 'h12);
    chk("R5", "slot 4 masked", slotVal(4), 'h10);

    curReq = "R6";
    sendWord(16'h8577);              // offset 0x05 not writable
    idle(1, 16'h0000);
    foreach (offs[i])
      if (i != 0 && i != 4) chk("R6", "untouched slot", slotVal(i), defOf(offs[i]));

    curReq = "R9";
    idle(3, 16'h0055);               // would hit offset 0x00 if taken
    chk("R9", "slot 0 held while idle", slotVal(0), 'h12);

    // R4: last word applied, next word parsed as header (back to back)
    curReq = "R4";
    sendWord(16'h439C);              // last word: offset 0x43 <- 0x9C
    curReq = "R7";
    sendWord(16'h8003);              // header, reserved function 3
    sendWord(16'hAC55);              // discarded
    sendWord(16'h3D66);              // discarded, closes run
    curReq = "R4";
    sendWord(16'hFFF8);              // header, reserved bits set, function 0
    sendWord(16'h2DAB);              // last word: offset 0x2D <- 0xAB
    idle(1, 16'h0000);
    chk("R4", "closing word applied", slotVal(14), 'h9C);
    chk("R7", "offset 0x2C discarded", slotVal(8), defOf('h2C));
    chk("R7", "offset 0x3D discarded", slotVal(12), defOf('h3D));
    chk("R3", "header reserved bits ignored", slotVal(9), 'hAB);

    curReq = "R8";
    sendWord(16'h0000);              // end of zone
    sendWord(16'h8000);
    sendWord(16'h00FF);
    idle(1, 16'h0000);
    chk("R8", "loadDone set", int'(loadDone), 1);
    chk("R8", "wordReady dropped", int'(wordReady), 0);
    chk("R8", "slot 0 frozen", slotVal(0), 'h12);
    idle(2, 16'h8000);
    chk("R8", "loadDone sticky", int'(loadDone), 1);
    summary();
  end
endmodule